// File: doc/BRIEF.md
# Banked Two-Stage Clock Divider

This block turns one fast clock into a bank of output clocks. It treats the fast clock as the output of a synthesizer oscillator. A shared prescaler divides the fast clock first. Each output then applies its own post-divider to the prescaled clock. The frequency of an output is therefore the input frequency divided by the product of the two ratios.

Every ratio register holds two values, a primary one and a secondary one. A bank-level select pin chooses which set drives the counters. The pin is synchronised, and a change of set waits for the prescaler to wrap. At that moment every post-divider restarts together, so the outputs of the bank stay phase-related. When the total ratio is odd, the divider uses a flop on the falling edge so that high and low times stay within half an input period of each other.

Each output has a two-bit drive mode, and the bank has an enable. Together they decide whether the true and complement pins drive or float. The drive is shown as an explicit enable per pin, with the pin data forced low whenever the pin floats. Ratios are written through parallel load strobes.

Top module: `cdiv_top`

## Requirements
- R1: A prescaler value is clamped to the range 4..259 when it is loaded. Below 4 it stores 4, and above 259 it stores 259.
- R2: A post-divider value is clamped to the range 1..16 when it is loaded. Below 1 it stores 1, and above 16 it stores 16.
- R3: Each output clock has a period of exactly P×Q input cycles, where P is the active prescaler ratio and Q is that output's active post ratio.
- R4: Each output is high for exactly P×Q half input periods out of every 2×P×Q. For odd products this relies on a falling-edge flop.
- R5: With `bankSel` high the primary set of ratios is active, and with it low the secondary set. After reset the primary set is active.
- R6: The active set changes only in a cycle where the prescaler is at its terminal count. All post-dividers restart at that moment, so outputs with equal new ratios produce identical waveforms from then on.
- R7: When `bankOe` is low, every true and complement enable is 0 and every output data pin is 0.
- R8: Output mode encoding per output: 2'b01 is differential, 2'b10 is single-ended, and 2'b00 or 2'b11 is off. Off leaves both pins floating even when `bankOe` is high. Single-ended drives only the true pin and holds the complement pin disabled and low.
- R9: A differential output's complement pin is always the inverse of its true pin.
- R10: A post ratio of 1 passes the prescaled clock through unchanged: period P and 50% duty.
- R11: During synchronous reset all outputs are low. After the first edge following release, all outputs rise in the same half-cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast input clock |
| rst | input | 1 | Synchronous reset, active high |
| bankSel | input | 1 | Ratio set select: 1 primary, 0 secondary (asynchronous) |
| bankOe | input | 1 | Bank output enable, active high |
| outMode | input | 2*NUM_OUT | Per-output drive mode, 2 bits each |
| ldPreEn | input | 1 | Load strobe for the prescaler ratio |
| ldPreSec | input | 1 | Prescaler slot to load: 0 primary, 1 secondary |
| ldPreVal | input | 9 | Prescaler ratio to load |
| ldPostEn | input | 1 | Load strobe for a post ratio |
| ldPostIdx | input | IDX_W | Output index for the post ratio load |
| ldPostSec | input | 1 | Post slot to load: 0 primary, 1 secondary |
| ldPostVal | input | 5 | Post ratio to load |
| clkTrue | output | NUM_OUT | True output clocks |
| clkComp | output | NUM_OUT | Complement output clocks |
| trueEn | output | NUM_OUT | Drive enable of each true pin |
| compEn | output | NUM_OUT | Drive enable of each complement pin |

## Verification
The bench builds the block with its default of three outputs and the full ratio limits. Four small prescaler values are swept against every post ratio from 1 to 16, across the three outputs. This covers odd and even products, pass-through at ratio 1, and both clamp edges, including the 259 maximum. Period and high time are measured at half-cycle resolution, so any duty error from the falling-edge path shows up directly. The select pin is switched between sets whose post ratios differ on one side and are equal on the other. This lets the restart-together behaviour be observed at the pins.

// File: rtl/cdiv_pkg.sv
`timescale 1ns/1ps
package cdiv_pkg;
  localparam int PRE_W    = 9;
  localparam int POST_W   = 5;
  localparam int PRE_MIN  = 4;
  localparam int PRE_MAX  = 259;
  localparam int POST_MIN = 1;
  localparam int POST_MAX = 16;

  typedef enum logic [1:0] {
    MODE_OFF  = 2'b00,
    MODE_DIFF = 2'b01,
    MODE_SE   = 2'b10,
    MODE_RSVD = 2'b11
  } outMode_e;

  // control -> datapath strobes
  typedef struct packed {
    logic             preTc;
    logic             reload;
    logic [PRE_W-1:0] preCnt;
  } divStrobe_t;
endpackage

// File: rtl/cdiv_ctrl.sv
`timescale 1ns/1ps
module cdiv_ctrl
  import cdiv_pkg::*;
#(
  parameter int NUM_OUT = 3,
  parameter int IDX_W   = 2
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic                      bankSel,
  input  logic                      ldPreEn,
  input  logic                      ldPreSec,
  input  logic [PRE_W-1:0]          ldPreVal,
  input  logic                      ldPostEn,
  input  logic [IDX_W-1:0]          ldPostIdx,
  input  logic                      ldPostSec,
  input  logic [POST_W-1:0]         ldPostVal,
  output divStrobe_t                strobe,
  output logic [PRE_W-1:0]          preRatio,
  output logic [NUM_OUT*POST_W-1:0] postRatio,
  output logic                      activeSec
);
  logic [1:0][PRE_W-1:0]               preSet;
  logic [NUM_OUT-1:0][1:0][POST_W-1:0] postSet;
  logic                                selMeta, selSync;
  logic [PRE_W-1:0]                    preCnt;
  logic                                preTc, reload;

  function automatic logic [PRE_W-1:0] clampPre(input logic [PRE_W-1:0] v);
    if (v < PRE_W'(PRE_MIN)) return PRE_W'(PRE_MIN);
    if (v > PRE_W'(PRE_MAX)) return PRE_W'(PRE_MAX);
    return v;
  endfunction

  function automatic logic [POST_W-1:0] clampPost(input logic [POST_W-1:0] v);
    if (v < POST_W'(POST_MIN)) return POST_W'(POST_MIN);
    if (v > POST_W'(POST_MAX)) return POST_W'(POST_MAX);
    return v;
  endfunction

  // ratio storage, clamped on the way in
  always_ff @(posedge clk) begin
    if (rst) begin
      preSet  <= {2{PRE_W'(PRE_MIN)}};
      postSet <= {(2*NUM_OUT){POST_W'(POST_MIN)}};
    end else begin
      if (ldPreEn) preSet[ldPreSec] <= clampPre(ldPreVal);
      if (ldPostEn && (int'(ldPostIdx) < NUM_OUT))
        postSet[ldPostIdx][ldPostSec] <= clampPost(ldPostVal);
    end
  end

  assign preRatio = preSet[activeSec];
  assign preTc    = (preCnt >= (preRatio - PRE_W'(1)));
  assign reload   = preTc && ((~selSync) != activeSec);

  // select synchroniser, set swap at terminal count, prescaler counter
  always_ff @(posedge clk) begin
    if (rst) begin
      selMeta   <= 1'b1;
      selSync   <= 1'b1;
      activeSec <= 1'b0;
      preCnt    <= '0;
    end else begin
      selMeta <= bankSel;
      selSync <= selMeta;
      if (reload) activeSec <= ~selSync;
      preCnt <= preTc ? '0 : preCnt + PRE_W'(1);
    end
  end

  always_comb begin
    strobe.preTc  = preTc;
    strobe.reload = reload;
    strobe.preCnt = preCnt;
  end

  for (genvar g = 0; g < NUM_OUT; g++) begin : g_post
    assign postRatio[g*POST_W +: POST_W] = postSet[g][activeSec];
  end
endmodule

// File: rtl/cdiv_datapath.sv
`timescale 1ns/1ps
module cdiv_datapath
  import cdiv_pkg::*;
#(
  parameter int NUM_OUT = 3
) (
  input  logic                      clk,
  input  logic                      rst,
  input  divStrobe_t                strobe,
  input  logic [PRE_W-1:0]          preRatio,
  input  logic [NUM_OUT*POST_W-1:0] postRatio,
  input  logic                      bankOe,
  input  logic [2*NUM_OUT-1:0]      outMode,
  output logic [NUM_OUT-1:0]        clkTrue,
  output logic [NUM_OUT-1:0]        clkComp,
  output logic [NUM_OUT-1:0]        trueEn,
  output logic [NUM_OUT-1:0]        compEn
);
  localparam int PH_W = PRE_W + POST_W;

  for (genvar g = 0; g < NUM_OUT; g++) begin : g_out
    logic [POST_W-1:0] postCnt, myPost;
    logic [PH_W-1:0]   phase, total, halfT;
    logic              hiReg, negReg, divClk, drive;
    outMode_e          mode;

    assign myPost = postRatio[g*POST_W +: POST_W];
    assign total  = PH_W'(preRatio) * PH_W'(myPost);
    assign halfT  = total >> 1;
    assign phase  = PH_W'(postCnt) * PH_W'(preRatio) + PH_W'(strobe.preCnt);

    always_ff @(posedge clk) begin
      if (rst) begin
        postCnt <= '0;
        hiReg   <= 1'b0;
      end else begin
        hiReg <= (phase < halfT);
        if (strobe.reload)
          postCnt <= '0;
        else if (strobe.preTc)
          postCnt <= (postCnt >= myPost - POST_W'(1)) ? '0 : postCnt + POST_W'(1);
      end
    end

    // half-period stretch for odd totals
    always_ff @(negedge clk) begin
      if (rst) negReg <= 1'b0;
      else     negReg <= hiReg;
    end

    assign divClk     = hiReg | (total[0] & negReg);
    assign mode       = outMode_e'(outMode[2*g +: 2]);
    assign drive      = bankOe && (mode == MODE_DIFF || mode == MODE_SE);
    assign trueEn[g]  = drive;
    assign compEn[g]  = drive && (mode == MODE_DIFF);
    assign clkTrue[g] = drive & divClk;
    assign clkComp[g] = compEn[g] & ~divClk;
  end
endmodule

// File: rtl/cdiv_top.sv
`timescale 1ns/1ps
module cdiv_top
  import cdiv_pkg::*;
#(
  parameter  int NUM_OUT = 3,
  localparam int IDX_W   = (NUM_OUT > 1) ? $clog2(NUM_OUT) : 1
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 bankSel,
  input  logic                 bankOe,
  input  logic [2*NUM_OUT-1:0] outMode,
  input  logic                 ldPreEn,
  input  logic                 ldPreSec,
  input  logic [PRE_W-1:0]     ldPreVal,
  input  logic                 ldPostEn,
  input  logic [IDX_W-1:0]     ldPostIdx,
  input  logic                 ldPostSec,
  input  logic [POST_W-1:0]    ldPostVal,
  output logic [NUM_OUT-1:0]   clkTrue,
  output logic [NUM_OUT-1:0]   clkComp,
  output logic [NUM_OUT-1:0]   trueEn,
  output logic [NUM_OUT-1:0]   compEn
);
  divStrobe_t                strobe;
  logic [PRE_W-1:0]          preRatio;
  logic [NUM_OUT*POST_W-1:0] postRatio;
  logic                      activeSec;

  cdiv_ctrl #(.NUM_OUT(NUM_OUT), .IDX_W(IDX_W)) u_ctrl (
    .clk(clk), .rst(rst), .bankSel(bankSel),
    .ldPreEn(ldPreEn), .ldPreSec(ldPreSec), .ldPreVal(ldPreVal),
    .ldPostEn(ldPostEn), .ldPostIdx(ldPostIdx), .ldPostSec(ldPostSec), .ldPostVal(ldPostVal),
    .strobe(strobe), .preRatio(preRatio), .postRatio(postRatio), .activeSec(activeSec)
  );

  cdiv_datapath #(.NUM_OUT(NUM_OUT)) u_dp (
    .clk(clk), .rst(rst), .strobe(strobe), .preRatio(preRatio), .postRatio(postRatio),
    .bankOe(bankOe), .outMode(outMode),
    .clkTrue(clkTrue), .clkComp(clkComp), .trueEn(trueEn), .compEn(compEn)
  );
endmodule

// File: rtl/cdiv_check.sv
`timescale 1ns/1ps
module cdiv_check
  import cdiv_pkg::*;
#(
  parameter int NUM_OUT = 3
) (
  input logic                      clk,
  input logic                      rst,
  input logic                      bankOe,
  input logic [2*NUM_OUT-1:0]      outMode,
  input logic [NUM_OUT-1:0]        clkTrue,
  input logic [NUM_OUT-1:0]        clkComp,
  input logic [NUM_OUT-1:0]        trueEn,
  input logic [NUM_OUT-1:0]        compEn,
  input logic                      preTc,
  input logic [PRE_W-1:0]          preCnt,
  input logic [PRE_W-1:0]          preRatio,
  input logic [NUM_OUT*POST_W-1:0] postRatio,
  input logic                      activeSec
);
  p_pre_range_r1: assert property (@(posedge clk) disable iff (rst)
    preRatio >= PRE_W'(PRE_MIN) && preRatio <= PRE_W'(PRE_MAX));

  for (genvar g = 0; g < NUM_OUT; g++) begin : g_chk
    p_post_range_r2: assert property (@(posedge clk) disable iff (rst)
      postRatio[g*POST_W +: POST_W] >= POST_W'(POST_MIN) &&
      postRatio[g*POST_W +: POST_W] <= POST_W'(POST_MAX));
    p_se_comp_off_r8: assert property (@(posedge clk) disable iff (rst)
      (outMode[2*g +: 2] == 2'b10) |-> (!compEn[g] && !clkComp[g]));
    p_off_float_r8: assert property (@(posedge clk) disable iff (rst)
      (outMode[2*g +: 2] == 2'b00 || outMode[2*g +: 2] == 2'b11) |-> (!trueEn[g] && !compEn[g]));
  end

  p_tc_wrap_r3: assert property (@(posedge clk) disable iff (rst)
    preTc |=> (preCnt == '0));

  p_swap_at_tc_r6: assert property (@(posedge clk) disable iff (rst)
    (activeSec != $past(activeSec)) |-> $past(preTc));

  p_bank_float_r7: assert property (@(posedge clk) disable iff (rst)
    !bankOe |-> (trueEn == '0 && compEn == '0 && clkTrue == '0 && clkComp == '0));

  p_comp_inverse_r9: assert property (@(posedge clk) disable iff (rst)
    ((clkComp & compEn) == (~clkTrue & compEn)) && ((compEn & ~trueEn) == '0));

  p_reset_low_r11: assert property (@(posedge clk)
    rst |=> (clkTrue == '0));
endmodule

bind cdiv_top cdiv_check #(.NUM_OUT(NUM_OUT)) u_check (
  .clk(clk), .rst(rst), .bankOe(bankOe), .outMode(outMode),
  .clkTrue(clkTrue), .clkComp(clkComp), .trueEn(trueEn), .compEn(compEn),
  .preTc(strobe.preTc), .preCnt(strobe.preCnt), .preRatio(preRatio),
  .postRatio(postRatio), .activeSec(activeSec)
);

// File: tb/cdiv_top_test.sv
`timescale 1ns/1ps
module cdiv_top_test;
  localparam int N = 3;

  logic       clk = 1'b0;
  logic       rst, bankSel, bankOe;
  logic [5:0] outMode;
  logic       ldPreEn, ldPreSec, ldPostEn, ldPostSec;
  logic [8:0] ldPreVal;
  logic [1:0] ldPostIdx;
  logic [4:0] ldPostVal;
  logic [N-1:0] clkTrue, clkComp, trueEn, compEn;

  int nChecks = 0;
  int nFail   = 0;
  int firstRise [N];

  always #2.5 clk = ~clk;

  cdiv_top #(.NUM_OUT(N)) uut (
    .clk(clk), .rst(rst), .bankSel(bankSel), .bankOe(bankOe), .outMode(outMode),
    .ldPreEn(ldPreEn), .ldPreSec(ldPreSec), .ldPreVal(ldPreVal),
    .ldPostEn(ldPostEn), .ldPostIdx(ldPostIdx), .ldPostSec(ldPostSec), .ldPostVal(ldPostVal),
    .clkTrue(clkTrue), .clkComp(clkComp), .trueEn(trueEn), .compEn(compEn)
  );

  task automatic check(input bit ok, input string req, input string what, input int act, input int exp);
    nChecks++;
    if (!ok) begin
      nFail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic waitHalf();
    @(clk);
    #1;
  endtask

  task automatic cycles(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic loadPre(input bit sec, input int val);
    ldPreEn = 1'b1; ldPreSec = sec; ldPreVal = 9'(val);
    cycles(1);
    ldPreEn = 1'b0;
  endtask

  task automatic loadPost(input int idx, input bit sec, input int val);
    ldPostEn = 1'b1; ldPostIdx = 2'(idx); ldPostSec = sec; ldPostVal = 5'(val);
    cycles(1);
    ldPostEn = 1'b0;
  endtask

  task automatic loadPosts(input bit sec, input int a, input int b, input int c);
    loadPost(0, sec, a);
    loadPost(1, sec, b);
    loadPost(2, sec, c);
  endtask

  // measure period and high time of every output in half input periods
  task automatic measure(input int t0, input int t1, input int t2, input string tagP);
    int expT [N];
    int rises [N], per [N], hi [N], cntP [N], cntH [N];
    bit prev [N];
    int maxT, limit;
    bit done;
    expT[0] = t0; expT[1] = t1; expT[2] = t2;
    maxT = t0;
    if (t1 > maxT) maxT = t1;
    if (t2 > maxT) maxT = t2;
    limit = 8 * maxT + 200;
    for (int o = 0; o < N; o++) begin
      rises[o] = 0; per[o] = -1; hi[o] = -1; cntP[o] = 0; cntH[o] = 0;
      prev[o] = clkTrue[o]; firstRise[o] = -1;
    end
    for (int s = 0; s < limit; s++) begin
      waitHalf();
      done = 1'b1;
      for (int o = 0; o < N; o++) begin
        if (clkTrue[o] && !prev[o]) begin
          if (rises[o] >= 1) begin per[o] = cntP[o]; hi[o] = cntH[o]; end
          if (rises[o] == 0) firstRise[o] = s;
          rises[o]++;
          cntP[o] = 0; cntH[o] = 0;
        end
        cntP[o]++;
        if (clkTrue[o]) cntH[o]++;
        prev[o] = clkTrue[o];
        if (rises[o] < 3) done = 1'b0;
      end
      if (done) break;
    end
    for (int o = 0; o < N; o++) begin
      check(per[o] == 2 * expT[o], tagP, $sformatf("period out%0d (half cycles)", o), per[o], 2 * expT[o]);
      check(hi[o] == expT[o], "R4", $sformatf("high time out%0d (half cycles)", o), hi[o], expT[o]);
    end
  endtask

  initial begin
    int pres [4];
    int q0, q1, q2, seen, same;
    pres[0] = 4; pres[1] = 5; pres[2] = 7; pres[3] = 9;
    rst = 1'b1; bankSel = 1'b1; bankOe = 1'b1; outMode = 6'b01_01_01;
    ldPreEn = 0; ldPreSec = 0; ldPreVal = '0;
    ldPostEn = 0; ldPostIdx = '0; ldPostSec = 0; ldPostVal = '0;

    // R11: reset state, then aligned first rise
    cycles(3);
    check(clkTrue == '0, "R11", "outputs low in reset", int'(clkTrue), 0);
    rst = 1'b0;
    measure(4, 4, 4, "R3");
    for (int o = 0; o < N; o++)
      check(firstRise[o] == 1, "R11", $sformatf("first rise sample out%0d", o), firstRise[o], 1);

    // R3/R4 sweep of prescaler values against all post ratios
    foreach (pres[i]) begin
      loadPre(0, pres[i]);
      for (int p = 1; p <= 16; p++) begin
        q0 = p; q1 = 17 - p; q2 = ((p * 5) % 16) + 1;
        loadPosts(0, q0, q1, q2);
        measure(pres[i] * q0, pres[i] * q1, pres[i] * q2, "R3");
      end
    end

    // R10: post ratio 1 is a pass-through of the prescaler
    loadPre(0, 7);
    loadPosts(0, 1, 1, 1);
    measure(7, 7, 7, "R10");

    // R1: prescaler clamps
    loadPre(0, 2);
    measure(4, 4, 4, "R1");
    loadPre(0, 300);
    measure(259, 259, 259, "R1");

    // R2: post clamps
    loadPre(0, 4);
    loadPosts(0, 0, 20, 31);
    measure(4, 64, 64, "R2");

    // R5/R6: primary vs secondary sets
    loadPre(0, 5);
    loadPosts(0, 2, 3, 4);
    loadPre(1, 6);
    loadPosts(1, 3, 3, 3);
    measure(10, 15, 20, "R5");
    bankSel = 1'b0;
    measure(18, 18, 18, "R5");
    cycles(20);
    same = 1;
    for (int s = 0; s < 200; s++) begin
      waitHalf();
      if (clkTrue[0] != clkTrue[1] || clkTrue[1] != clkTrue[2]) same = 0;
    end
    check(same == 1, "R6", "post dividers restarted together", same, 1);
    bankSel = 1'b1;
    measure(10, 15, 20, "R5");

    // R7: bank disable floats everything
    loadPre(0, 4);
    loadPosts(0, 1, 2, 3);
    bankOe = 1'b0;
    seen = 0;
    for (int s = 0; s < 40; s++) begin
      waitHalf();
      if (clkTrue != '0 || clkComp != '0) seen = 1;
    end
    check(trueEn == '0, "R7", "trueEn with bank off", int'(trueEn), 0);
    check(compEn == '0, "R7", "compEn with bank off", int'(compEn), 0);
    check(seen == 0, "R7", "data activity with bank off", seen, 0);

    // R8: off / single-ended / reserved modes
    bankOe = 1'b1;
    outMode = 6'b11_10_00;
    waitHalf();
    check(trueEn == 3'b010, "R8", "trueEn per mode", int'(trueEn), 2);
    check(compEn == 3'b000, "R8", "compEn per mode", int'(compEn), 0);
    seen = 0; same = 0;
    for (int s = 0; s < 40; s++) begin
      waitHalf();
      if (clkComp != '0 || clkTrue[0] || clkTrue[2]) seen = 1;
      if (clkTrue[1]) same = 1;
    end
    check(seen == 0, "R8", "disabled pins stay low", seen, 0);
    check(same == 1, "R8", "single-ended true pin toggles", same, 1);

    // R9: differential complement
    outMode = 6'b01_01_01;
    waitHalf();
    check(compEn == 3'b111, "R9", "compEn differential", int'(compEn), 7);
    seen = 0;
    for (int s = 0; s < 40; s++) begin
      waitHalf();
      if (clkComp != ~clkTrue) seen = 1;
    end
    check(seen == 0, "R9", "complement mismatch", seen, 0);

    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFail);
    $finish;
  end

  initial begin
    #(150000 * 5);
    nChecks++;
    nFail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFail);
    $finish;
  end
endmodule